// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the two timing strobes an asynchronous serial port needs from a fast system clock. The first is an oversampling strobe at sixteen times the bit rate. The second is a strobe that fires once per bit period. The divide chain has three stages. A 9-bit phase accumulator trims the clock by a fraction F/512 and can be switched out. An integer down-counter then divides by RELOAD+1. A final divide-by-16 stage produces the per-bit strobe. The resulting bit rate is (F/512) · fclk / (16 · (RELOAD+1)).

Software selects the divisor values and programs them through a small write port. That port has three targets: control, fraction and reload. The divisor fields are only accepted while the generator is halted. Halting the generator also clears every counter, so the first strobes after a start arrive at a fixed, predictable time. Both strobes are registered and last one system-clock cycle per event.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is asserted and immediately after it, both strobes are low and the generator is halted.
- R2: A write with `wr_sel`=0 sets the control state: `wr_data` bit 15 is the run bit and bit 9 is the fraction-enable bit. While the run bit is 0, neither strobe is ever raised.
- R3: With the fraction stage disabled, the down-counter advances on every clock, and the oversample strobe repeats every RELOAD+1 cycles. RELOAD is written with `wr_sel`=2 from the low bits of `wr_data`.
- R4: With the fraction stage enabled, a 9-bit accumulator adds F on every clock and grants one count step on each carry past 512. F is written with `wr_sel`=1 from `wr_data[8:0]`. F=0 acts as 512, so a step is granted on every clock.
- R5: The down-counter raises the oversample strobe and reloads RELOAD when it sits at zero and a count step arrives. RELOAD=0 therefore gives one oversample strobe per count step.
- R6: The per-bit strobe fires together with the 1st, 17th, 33rd, … oversample strobes after a start. It is never high without the oversample strobe, and never high in two consecutive cycles.
- R7: Halting clears the accumulator and both counters. After the clock edge that captures the run bit, the first strobes appear c+1 cycles later, where c is the index of the first cycle with a count step (cycle 0 is the first running cycle). With the fraction stage off, both strobes appear one cycle after that edge.
- R8: Writes to F, RELOAD or the fraction-enable bit made while running are ignored. Only the run bit of a control write takes effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Write target: 0 control, 1 fraction, 2 reload |
| wr_data | input | 16 | Write data |
| os_tick | output | 1 | Oversample strobe (16x bit rate) |
| bit_tick | output | 1 | Per-bit strobe |

## Verification
The assertions take `wr_sel` values of 0, 1 and 2 as the only meaningful targets, and take writes as synchronous, one-cycle `wr_en` pulses. The per-bit strobe checks also rely on the generator being halted and restarted before any divisor change. The stimulus follows these rules. It drives every write at the falling edge for exactly one cycle. It stops the generator before reprogramming, except in the deliberate tests that write divisor fields while running to show they are ignored.

// File: rtl/baud_frac_gen_pkg.sv
package baud_frac_gen_pkg;

    // control-register field positions decoded by the register stage
    localparam int RUN_BIT = 15;
    localparam int FEN_BIT = 9;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_FRAC   = 2'd1,
        SEL_RELOAD = 2'd2
    } wsel_e;

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_frac_gen_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int FRAC_W   = 9,
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                run_o,
    output logic                fen_o,
    output logic [FRAC_W-1:0]   frac_o,
    output logic [RELOAD_W-1:0] reload_o
);

    typedef struct packed {
        logic                run;
        logic                fen;
        logic [FRAC_W-1:0]   frac;
        logic [RELOAD_W-1:0] reload;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.run = wr_data[RUN_BIT];
                    if (!st_q.run) st_d.fen = wr_data[FEN_BIT];
                end
                SEL_FRAC: begin
                    if (!st_q.run) st_d.frac = wr_data[FRAC_W-1:0];
                end
                SEL_RELOAD: begin
                    if (!st_q.run) st_d.reload = wr_data[RELOAD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign fen_o    = st_q.fen;
    assign frac_o   = st_q.frac;
    assign reload_o = st_q.reload;

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int FRAC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              fen_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              step_o
);

    localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_t;

    acc_t            st_d, st_q;
    logic [FRAC_W:0] addend;
    logic [FRAC_W:0] sum;

    always_comb begin
        st_d   = st_q;
        addend = (frac_i == '0) ? FULL : {1'b0, frac_i};
        sum    = {1'b0, st_q.acc} + addend;
        step_o = 1'b0;
        if (!run_i) begin
            st_d.acc = '0;
        end else if (!fen_i) begin
            st_d.acc = '0;
            step_o   = 1'b1;
        end else begin
            st_d.acc = sum[FRAC_W-1:0];
            step_o   = sum[FRAC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/baud_reload_cnt.sv
module baud_reload_cnt #(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                step_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                fire_o,
    output logic                os_tick_o
);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic                tick;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        fire_o    = 1'b0;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (st_q.cnt == '0) begin
                fire_o    = 1'b1;
                st_d.tick = 1'b1;
                st_d.cnt  = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign os_tick_o = st_q.tick;

endmodule

// File: rtl/baud_os_div.sv
module baud_os_div #(
    parameter int OS_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fire_i,
    output logic bit_tick_o
);

    localparam int              DIV_W = $clog2(OS_RATIO);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(OS_RATIO - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (fire_i) begin
            if (st_q.cnt == '0) begin
                st_d.tick = 1'b1;
                st_d.cnt  = LAST;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_tick_o = st_q.tick;

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int DATA_W   = 16,
    parameter int FRAC_W   = 9,
    parameter int RELOAD_W = 16,
    parameter int OS_RATIO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              os_tick,
    output logic              bit_tick
);

    logic                run_q;
    logic                fen_q;
    logic [FRAC_W-1:0]   frac_q;
    logic [RELOAD_W-1:0] reload_q;
    logic                step;
    logic                fire;

    baud_regs #(
        .DATA_W  (DATA_W),
        .FRAC_W  (FRAC_W),
        .RELOAD_W(RELOAD_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .run_o   (run_q),
        .fen_o   (fen_q),
        .frac_o  (frac_q),
        .reload_o(reload_q)
    );

    baud_frac_acc #(.FRAC_W(FRAC_W)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_q),
        .fen_i (fen_q),
        .frac_i(frac_q),
        .step_o(step)
    );

    baud_reload_cnt #(.RELOAD_W(RELOAD_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .step_i   (step),
        .reload_i (reload_q),
        .fire_o   (fire),
        .os_tick_o(os_tick)
    );

    baud_os_div #(.OS_RATIO(OS_RATIO)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .fire_i    (fire),
        .bit_tick_o(bit_tick)
    );

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
    parameter int RELOAD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic                run_q,
    input logic                fen_q,
    input logic [RELOAD_W-1:0] reload_q,
    input logic                os_tick,
    input logic                bit_tick
);

    // R2
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (!os_tick && !bit_tick));

    // R6
    bit_in_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R6
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R8
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_en && wr_sel == 2'd2) |=> $stable(reload_q));

    // R7
    start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_q) && !fen_q) |=> (os_tick && bit_tick));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(.RELOAD_W(RELOAD_W)) chk_i (.*);

// File: tb/baud_frac_gen_tb_top.sv
module baud_frac_gen_tb_top;

    localparam int CLK_NS = 20;

    typedef struct packed {
        logic        fe;
        logic [8:0]  frac;
        logic [15:0] rel;
        logic [15:0] first;
        logic [15:0] os_per;
        logic [15:0] bit_per;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{fe:1'b0, frac:9'd0,   rel:16'd0, first:16'd1, os_per:16'd1, bit_per:16'd16},
        '{fe:1'b0, frac:9'd128, rel:16'd3, first:16'd1, os_per:16'd4, bit_per:16'd64},
        '{fe:1'b1, frac:9'd0,   rel:16'd2, first:16'd1, os_per:16'd3, bit_per:16'd48},
        '{fe:1'b1, frac:9'd256, rel:16'd0, first:16'd2, os_per:16'd2, bit_per:16'd32},
        '{fe:1'b1, frac:9'd128, rel:16'd1, first:16'd4, os_per:16'd8, bit_per:16'd128},
        '{fe:1'b1, frac:9'd384, rel:16'd2, first:16'd2, os_per:16'd4, bit_per:16'd64},
        '{fe:1'b1, frac:9'd511, rel:16'd0, first:16'd2, os_per:16'd1, bit_per:16'd16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        os_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    baud_frac_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .os_tick (os_tick),
        .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [15:0] ctrl(input bit run, input bit fe);
        return (16'(run) << 15) | (16'(fe) << 9);
    endfunction

    task automatic setup(input bit fe, input logic [8:0] f, input logic [15:0] r);
        wr(2'd0, ctrl(1'b0, 1'b0));
        wr(2'd1, {7'd0, f});
        wr(2'd2, r);
        wr(2'd0, ctrl(1'b1, fe));
    endtask

    task automatic measure(output int os1, output int os2, output int b1, output int b2);
        os1 = 0; os2 = 0; b1 = 0; b2 = 0;
        for (int t = 1; t <= 700 && b2 == 0; t++) begin
            @(negedge clk);
            if (os_tick) begin
                if (os1 == 0) os1 = t;
                else if (os2 == 0) os2 = t;
            end
            if (bit_tick) begin
                if (b1 == 0) b1 = t;
                else if (b2 == 0) b2 = t;
            end
        end
    endtask

    task automatic count_os(input int n, output int cnt);
        cnt = 0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (os_tick || bit_tick) cnt++;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int os1, os2, b1, b2, cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!os_tick && !bit_tick, "R1", int'({os_tick, bit_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!os_tick && !bit_tick, "R1", int'({os_tick, bit_tick}), 0);

        // R2: halted generator stays quiet, even with divisors programmed
        count_os(30, cnt);
        check(cnt == 0, "R2", cnt, 0);
        wr(2'd2, 16'd0);
        wr(2'd0, ctrl(1'b0, 1'b0));
        count_os(30, cnt);
        check(cnt == 0, "R2", cnt, 0);

        // table of divisor settings
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].fe, VECS[i].frac, VECS[i].rel);
            measure(os1, os2, b1, b2);
            check(os1 == int'(VECS[i].first), "R7", os1, int'(VECS[i].first));
            check(os2 - os1 == int'(VECS[i].os_per), VECS[i].fe ? "R4 R5" : "R3 R5",
                  os2 - os1, int'(VECS[i].os_per));
            check(b1 == os1, "R6", b1, os1);
            check(b2 - b1 == int'(VECS[i].bit_per), "R6", b2 - b1, int'(VECS[i].bit_per));
        end

        // R8: reload write while running is ignored
        setup(1'b0, 9'd0, 16'd0);
        wr(2'd2, 16'd9);
        cnt = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (os_tick) cnt++;
        end
        check(cnt == 20, "R8", cnt, 20);
        wr(2'd0, ctrl(1'b0, 1'b0));
        wr(2'd0, ctrl(1'b1, 1'b0));
        measure(os1, os2, b1, b2);
        check(os2 - os1 == 1, "R8", os2 - os1, 1);

        // R8: fraction write while running is ignored
        setup(1'b1, 9'd256, 16'd0);
        wr(2'd1, 16'd128);
        cnt = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (os_tick) cnt++;
        end
        check(cnt == 20, "R8", cnt, 20);

        // R8: fraction-enable change while running is ignored
        wr(2'd0, ctrl(1'b1, 1'b0));
        cnt = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (os_tick) cnt++;
        end
        check(cnt == 20, "R8", cnt, 20);

        // R7: halting mid-count clears the chain, restart timing is fixed
        setup(1'b0, 9'd0, 16'd5);
        repeat (3) @(negedge clk);
        wr(2'd0, ctrl(1'b0, 1'b0));
        count_os(10, cnt);
        check(cnt == 0, "R2", cnt, 0);
        wr(2'd0, ctrl(1'b1, 1'b0));
        measure(os1, os2, b1, b2);
        check(os1 == 1, "R7", os1, 1);
        check(b1 == 1, "R7", b1, 1);
        check(os2 - os1 == 6, "R3", os2 - os1, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule